// File: doc/BRIEF.md
# Tuning-Port I2C Target

This block is the bus-facing end of a frequency synthesizer's control port. It watches the two I2C lines and detects START and STOP conditions. It compares each address byte with one of four local addresses and acknowledges a match by pulling SDA low. In a write transaction it passes every data byte it receives to a downstream register decoder, together with a one-cycle valid strobe and a strobe that marks the STOP. In a read transaction it shifts out a status byte. That byte carries a sticky power-on-reset flag and the current lock state.

SCL and SDA are sampled on a system clock that runs at least sixteen times faster than SCL, so both standard-mode and fast-mode bus timing are handled. The supply-drop and lock indications arrive as synchronous inputs. SDA leaves the block as an open-drain enable: a 1 on that output pulls the line low.

Top module: `tune_i2c_target`

## Requirements
- R1: SDA falling while SCL is high is a START. From any state, including in the middle of a transaction (a repeated START), it begins reception of a new address byte. SDA rising while SCL is high is a STOP, and a STOP returns the block to idle.
- R2: The 7-bit local address is `{ADDR_PREFIX, addr_sel}`, where `ADDR_PREFIX` defaults to 5'b11000. Bit 0 of the address byte selects the direction: 0 for write, 1 for read. On a match the block holds SDA low through the 9th clock. On a mismatch it does not acknowledge, and it ignores the bus until the next START.
- R3: In a write transaction, each data byte (sent MSB first) is acknowledged. It appears on `rx_data` with a single-cycle `rx_valid` pulse after its 8th bit.
- R4: A STOP that ends a write transaction gives a single-cycle `rx_stop` pulse. A byte cut short by a STOP is never delivered.
- R5: In a read transaction the status byte is sent MSB first. Bit 7 is the power-on-reset flag, bit 6 is `lock_i`, and bits 5..0 are 0. SDA changes only while SCL is low.
- R6: When the controller acknowledges a status byte, another status byte follows.
- R7: When the controller does not acknowledge a status byte, the block ends the transfer internally. It then leaves SDA released until a new START and a matching address arrive.
- R8: The power-on-reset flag is 1 after reset, and it is set whenever `supply_drop` is high.
- R9: The power-on-reset flag clears only on a STOP that ends a read transaction. A repeated START, or a STOP that ends a write, leaves it set.
- R10: If `supply_drop` is high in the same cycle as a clearing STOP, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| addr_sel | input | 2 | Selects the low two address bits |
| supply_drop | input | 1 | Supply undervoltage indication; sets the power-on-reset flag |
| lock_i | input | 1 | Synthesizer lock indication |
| sda_oe | output | 1 | 1 pulls SDA low |
| rx_data | output | 8 | Last received write data byte |
| rx_valid | output | 1 | One-cycle strobe: `rx_data` holds a new byte |
| rx_stop | output | 1 | One-cycle strobe: a write transaction ended with STOP |

## Verification
Two things can happen in the same cycle. The STOP that ends a read sequence clears the power-on-reset flag, and a supply drop sets it. The bench provokes this by holding `supply_drop` high across that STOP. It judges the result at the ports: the next read must still return the flag as 1, and a later clean read-and-STOP must return it as 0. The repeated-START case is judged the same way, through the status byte.

// File: rtl/tune_i2c_target.sv
module tune_i2c_target #(
  parameter logic [4:0] ADDR_PREFIX = 5'b11000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] addr_sel,
  input  logic       supply_drop,
  input  logic       lock_i,
  output logic       sda_oe,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       rx_stop
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_WDATA, S_WACK, S_RDATA, S_RACK} st_t;

  logic [SYNC_STAGES-1:0] scl_sy, sda_sy;
  logic scl_q, sda_q, por_q, wr_act, rd_act;
  logic [7:0] sr;
  logic [3:0] cnt;
  st_t st;

  wire scl_s = scl_sy[SYNC_STAGES-1];
  wire sda_s = sda_sy[SYNC_STAGES-1];
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det = scl_s & scl_q & ~sda_q & sda_s;
  wire [7:0] status = {por_q, lock_i, 6'b0};
  wire addr_hit = sr[7:1] == {ADDR_PREFIX, addr_sel};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[SYNC_STAGES-2:0], scl_i};
      sda_sy <= {sda_sy[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sr <= '0; sda_oe <= 1'b0;
      rx_data <= '0; rx_valid <= 1'b0; rx_stop <= 1'b0;
      wr_act <= 1'b0; rd_act <= 1'b0; por_q <= 1'b1;
    end else begin
      rx_valid <= 1'b0;
      rx_stop  <= 1'b0;
      if (start_det) begin
        st <= S_ADDR; cnt <= '0; sda_oe <= 1'b0;
        wr_act <= 1'b0; rd_act <= 1'b0;
      end else if (stop_det) begin
        st <= S_IDLE; sda_oe <= 1'b0;
        rx_stop <= wr_act;
        if (rd_act) por_q <= 1'b0;
        wr_act <= 1'b0; rd_act <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_WDATA: begin
            if (scl_rise) begin
              sr  <= {sr[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (st == S_ADDR) begin
                if (addr_hit) begin
                  st <= S_AACK; sda_oe <= 1'b1;
                  wr_act <= ~sr[0]; rd_act <= sr[0];
                end else begin
                  st <= S_IDLE;
                end
              end else begin
                rx_data <= sr; rx_valid <= 1'b1;
                st <= S_WACK; sda_oe <= 1'b1;
              end
            end
          end
          S_AACK, S_WACK: if (scl_fall) begin
            cnt <= '0;
            if (st == S_AACK && rd_act) begin
              sr <= status; sda_oe <= ~status[7]; st <= S_RDATA;
            end else begin
              sda_oe <= 1'b0; st <= S_WDATA;
            end
          end
          S_RDATA: if (scl_fall) begin
            if (cnt == 4'd7) begin
              st <= S_RACK; sda_oe <= 1'b0; cnt <= '0;
            end else begin
              cnt <= cnt + 4'd1;
              sr <= {sr[6:0], 1'b0};
              sda_oe <= ~sr[6];
            end
          end
          S_RACK: begin
            if (scl_rise) begin
              if (sda_s) st <= S_IDLE;
              else cnt <= 4'd1;
            end else if (scl_fall && cnt == 4'd1) begin
              cnt <= '0; sr <= status; sda_oe <= ~status[7]; st <= S_RDATA;
            end
          end
          default: ;
        endcase
      end
      if (supply_drop) por_q <= 1'b1;
    end
  end

  // R1
  start_to_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == S_ADDR && !sda_oe));
  // R3
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R5
  sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
  // R7
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe);
  // R8
  por_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    supply_drop |=> por_q);
  // R9
  por_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(por_q) |-> $past(stop_det));

endmodule

// File: tb/tune_i2c_target_tb_top.sv
module tune_i2c_target_tb_top;
  localparam int Q = 10;
  localparam logic [4:0] PRE = 5'b11000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_h = 1'b1;
  logic host_low = 1'b0;
  logic [1:0] addr_sel = 2'd1;
  logic supply_drop = 1'b0;
  logic lock_i = 1'b1;
  logic sda_oe, rx_valid, rx_stop;
  logic [7:0] rx_data;
  wire sda_line = ~(host_low | sda_oe);

  int checks = 0, fails = 0, rx_n = 0, stop_n = 0;
  logic [7:0] rx_log [0:15];
  bit done = 0;

  always #2.5 clk = ~clk;

  tune_i2c_target dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_line),
    .addr_sel(addr_sel), .supply_drop(supply_drop), .lock_i(lock_i),
    .sda_oe(sda_oe), .rx_data(rx_data), .rx_valid(rx_valid), .rx_stop(rx_stop)
  );

  always @(posedge clk) begin
    if (rx_valid) begin
      rx_log[rx_n[3:0]] <= rx_data;
      rx_n <= rx_n + 1;
    end
    if (rx_stop) stop_n <= stop_n + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    host_low = 1'b0; half(); scl_h = 1'b1; half(); host_low = 1'b1; half(); scl_h = 1'b0; half();
  endtask

  task automatic bus_stop();
    host_low = 1'b1; half(); scl_h = 1'b1; half(); host_low = 1'b0; half();
  endtask

  task automatic clk_bit(input logic b, output logic seen);
    host_low = ~b; half(); scl_h = 1'b1; half(); seen = sda_line; half(); scl_h = 1'b0; half();
  endtask

  task automatic write_byte(input logic [7:0] d, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) clk_bit(d[i], x);
    clk_bit(1'b1, x);
    ack = ~x;
  endtask

  task automatic read_byte(input logic give_ack, output logic [7:0] d);
    logic x;
    for (int i = 7; i >= 0; i--) clk_bit(1'b1, d[i]);
    clk_bit(~give_ack, x);
  endtask

  task automatic t_reset();
    check(sda_oe == 1'b0, "R8 reset sda_oe", sda_oe, 0);
    check(rx_valid == 1'b0 && rx_stop == 1'b0, "R3 reset strobes", {rx_valid, rx_stop}, 0);
  endtask

  task automatic t_read_nack();
    logic a; logic [7:0] d;
    bus_start();
    write_byte({PRE, 2'd1, 1'b1}, a);
    check(a, "R2 read address ack", a, 1);
    read_byte(1'b1, d);
    check(d == 8'hC0, "R5 R8 first status byte", d, 8'hC0);
    read_byte(1'b0, d);
    check(d == 8'hC0, "R6 status after ack", d, 8'hC0);
    read_byte(1'b0, d);
    check(d == 8'hFF, "R7 no data after nack", d, 8'hFF);
    bus_stop();
  endtask

  task automatic t_por_cleared();
    logic a; logic [7:0] d;
    lock_i = 1'b0;
    bus_start(); write_byte({PRE, 2'd1, 1'b1}, a); read_byte(1'b0, d); bus_stop();
    check(d == 8'h00, "R9 flag cleared by read stop", d, 8'h00);
    lock_i = 1'b1;
  endtask

  task automatic t_rep_start();
    logic a; logic [7:0] d;
    @(negedge clk); supply_drop = 1'b1; @(negedge clk); supply_drop = 1'b0;
    bus_start(); write_byte({PRE, 2'd1, 1'b1}, a); read_byte(1'b0, d);
    check(d == 8'hC0, "R8 flag set by supply drop", d, 8'hC0);
    bus_start(); write_byte({PRE, 2'd1, 1'b1}, a);
    check(a, "R1 repeated start address ack", a, 1);
    read_byte(1'b0, d);
    check(d == 8'hC0, "R9 repeated start keeps flag", d, 8'hC0);
    bus_stop();
  endtask

  task automatic t_write();
    logic a, a1, a2, a3; logic [7:0] d;
    int n0 = rx_n, s0 = stop_n;
    @(negedge clk); supply_drop = 1'b1; @(negedge clk); supply_drop = 1'b0;
    bus_start(); write_byte({PRE, 2'd1, 1'b0}, a);
    write_byte(8'h5A, a1); write_byte(8'h00, a2); write_byte(8'hFF, a3);
    bus_stop();
    half();
    check(a && a1 && a2 && a3, "R3 all write bytes acked", {a, a1, a2, a3}, 4'hF);
    check(rx_n - n0 == 3, "R3 byte count", rx_n - n0, 3);
    check(rx_log[n0[3:0]] == 8'h5A && rx_log[n0[3:0] + 4'd1] == 8'h00 && rx_log[n0[3:0] + 4'd2] == 8'hFF,
          "R3 byte values", rx_log[n0[3:0]], 8'h5A);
    check(stop_n - s0 == 1, "R4 stop strobe", stop_n - s0, 1);
    bus_start(); write_byte({PRE, 2'd1, 1'b1}, a); read_byte(1'b0, d); bus_stop();
    check(d == 8'hC0, "R9 write stop keeps flag", d, 8'hC0);
  endtask

  task automatic t_wrong_addr();
    logic a, a1;
    int n0 = rx_n, s0 = stop_n;
    addr_sel = 2'd2;
    bus_start(); write_byte({PRE, 2'd3, 1'b0}, a); write_byte(8'h33, a1); bus_stop();
    half();
    check(!a && !a1, "R2 mismatch not acked", {a, a1}, 0);
    check(rx_n == n0 && stop_n == s0, "R2 mismatch ignored", rx_n - n0, 0);
    bus_start(); write_byte({PRE, 2'd2, 1'b0}, a); bus_stop();
    check(a, "R2 addr_sel 2 acked", a, 1);
  endtask

  task automatic t_partial();
    logic a, a1, x;
    int n0 = rx_n, s0 = stop_n;
    half();
    bus_start(); write_byte({PRE, 2'd2, 1'b0}, a); write_byte(8'h11, a1);
    for (int i = 0; i < 4; i++) clk_bit(1'b1, x);
    bus_stop(); half();
    check(rx_n - n0 == 1 && rx_log[n0[3:0]] == 8'h11, "R4 partial byte dropped", rx_n - n0, 1);
    check(stop_n - s0 == 1, "R4 stop after partial", stop_n - s0, 1);
  endtask

  task automatic t_collide();
    logic a; logic [7:0] d;
    addr_sel = 2'd1;
    bus_start(); write_byte({PRE, 2'd1, 1'b1}, a); read_byte(1'b0, d);
    host_low = 1'b1; half(); scl_h = 1'b1; half();
    supply_drop = 1'b1; half(); host_low = 1'b0; half(); supply_drop = 1'b0; half();
    bus_start(); write_byte({PRE, 2'd1, 1'b1}, a); read_byte(1'b0, d); bus_stop();
    check(d == 8'hC0, "R10 supply drop wins over stop", d, 8'hC0);
    bus_start(); write_byte({PRE, 2'd1, 1'b1}, a); read_byte(1'b0, d); bus_stop();
    check(d == 8'h40, "R10 later stop clears", d, 8'h40);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_read_nack();
    t_por_cleared();
    t_rep_start();
    t_write();
    t_wrong_addr();
    t_partial();
    t_collide();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule